// File: doc/BRIEF.md
# Quadword Load/Store Beat Splitter

This block sits between a core's 128-bit register file and a 64-bit memory port. It accepts one quadword load or store request and turns it into two 64-bit memory beats. The effective address is the base value plus a sign-extended offset. The low address bits are then cleared to force 16-byte alignment; a misaligned address never faults. The lower half of the register always travels first at the aligned address. The upper half follows at the aligned address plus eight.

For a load, both returned halves are kept internally. They are presented together with a write strobe and the destination index only when the sequence ends, in a one-cycle completion pulse. A load aimed at register index zero skips memory entirely and completes on the next cycle. A store from index zero still writes both beats, with zero data.

The sequencer has four states:
- `ST_IDLE` accepts a request.
- `ST_BEAT0` issues the low beat.
- `ST_BEAT1` issues the high beat.
- `ST_DONE` raises the completion pulse.

Its transitions are:
- IDLE to BEAT0 on an accepted request that needs memory.
- IDLE to DONE on an accepted load to index zero.
- BEAT0 to BEAT1 when memory accepts the low beat.
- BEAT1 to DONE when memory accepts the high beat.
- DONE to IDLE unconditionally.

Top module: `qw_beat_splitter`

## Requirements
- R1: The first beat's address equals (req_base + sign-extended req_offset) with its low 4 bits forced to zero.
- R2: The first beat carries the low half: for stores mem_wdata = req_wdata[63:0], and for loads the data returned on that beat becomes done_data[63:0].
- R3: The second beat follows the first and uses the first beat's address plus 8. It carries req_wdata[127:64] for stores, and its returned data becomes done_data[127:64] for loads.
- R4: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_write and mem_wdata stay unchanged. Each beat waits for mem_ready before advancing.
- R5: A load (req_is_store = 0) with req_reg_idx = 0 issues no memory beat. Its done pulse appears in the first cycle after acceptance.
- R6: A store with req_reg_idx = 0 still issues both beats, with mem_write = 1 and mem_wdata = 0 on each.
- R7: done_wr is high only during done, and only for a load with a nonzero index. done_idx then equals the request's index. done_data is zero whenever done_wr is low.
- R8: done is a one-cycle pulse. For a two-beat operation it appears 3 + (wait cycles) cycles after acceptance.
- R9: req_ready is high only in the idle state. A req_valid raised while an operation is running has no effect on the beats issued.
- R10: After reset the block is idle: req_ready = 1, and mem_valid, done, done_wr and done_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_base | input | ADDR_W | Base address value |
| req_offset | input | OFF_W | Signed byte offset |
| req_reg_idx | input | IDX_W | Source (store) or destination (load) register index |
| req_wdata | input | 2*BEAT_W | Quadword store data |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | BEAT_W | Beat write data |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | BEAT_W | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| done_wr | output | 1 | Register write strobe for loads |
| done_idx | output | IDX_W | Register index of the completed operation |
| done_data | output | 2*BEAT_W | Assembled load value |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit offset, 64-bit beats and 5-bit register indices. Its memory model inserts zero, one or two wait cycles on every beat. Offsets are swept from -17 to +17 around three base values, one aligned and two misaligned. This makes every residue of the low four address bits reachable, along with both signs of offset and carries across the 16-byte boundary. The sweep therefore covers alignment, beat order, stall holding and latency together. Index-zero loads and stores, and a request raised mid-operation, are exercised at each wait setting.

// File: rtl/qwbs_pkg.sv
package qwbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2,
        ST_DONE  = 2'd3
    } qwbs_state_e;

endpackage

// File: rtl/qwbs_addr_gen.sv
module qwbs_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int ALIGN_BITS = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] aligned
);
    localparam int EXT_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] sum;

    generate
        if (EXT_W > 0) begin : g_sext
            assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    // Low bits are dropped rather than reported as a misalignment.
    assign sum     = base + off_ext;
    assign aligned = sum & ~LOW_MASK;

endmodule

// File: rtl/qwbs_fsm.sv
module qwbs_fsm
    import qwbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_is_store,
    input  logic        req_idx_zero,
    input  logic        mem_ready,
    output qwbs_state_e state,
    output logic        accept,
    output logic        beat_active,
    output logic        beat_hi,
    output logic        fire_lo,
    output logic        fire_hi,
    output logic        in_done,
    output logic        idle
);
    qwbs_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_is_store && req_idx_zero) nxt = ST_DONE;
                    else                               nxt = ST_BEAT0;
                end
            end
            ST_BEAT0: if (mem_ready) nxt = ST_BEAT1;
            ST_BEAT1: if (mem_ready) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        idle        = 1'b0;
        beat_active = 1'b0;
        beat_hi     = 1'b0;
        in_done     = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_BEAT0: beat_active = 1'b1;
            ST_BEAT1: begin
                beat_active = 1'b1;
                beat_hi     = 1'b1;
            end
            ST_DONE:  in_done = 1'b1;
            default:  idle = 1'b0;
        endcase
        accept  = idle && req_valid;
        fire_lo = (state == ST_BEAT0) && mem_ready;
        fire_hi = (state == ST_BEAT1) && mem_ready;
    end

    // R8: the completion state never lasts more than one cycle
    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DONE |=> state == ST_IDLE);

    // R4: the low beat is never left until memory takes it
    p_beat0_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEAT0 && !mem_ready) |=> state == ST_BEAT0);

endmodule

// File: rtl/qwbs_datapath.sv
module qwbs_datapath #(
    parameter int BEAT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              zero_src,
    input  logic [2*BEAT_W-1:0] wdata_in,
    input  logic              beat_hi,
    input  logic              fire_lo,
    input  logic              fire_hi,
    input  logic              capture_rd,
    input  logic [BEAT_W-1:0] rdata,
    input  logic              commit,
    output logic [BEAT_W-1:0] beat_wdata,
    output logic [2*BEAT_W-1:0] result
);
    logic [2*BEAT_W-1:0] st_q;
    logic [BEAT_W-1:0]   lo_q;
    logic [BEAT_W-1:0]   hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (accept) begin
            st_q <= zero_src ? '0 : wdata_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (fire_lo && capture_rd) lo_q <= rdata;
            if (fire_hi && capture_rd) hi_q <= rdata;
        end
    end

    assign beat_wdata = beat_hi ? st_q[2*BEAT_W-1:BEAT_W] : st_q[BEAT_W-1:0];
    assign result     = commit ? {hi_q, lo_q} : '0;

endmodule

// File: rtl/qw_beat_splitter.sv
module qw_beat_splitter
    import qwbs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int BEAT_W     = 64,
    parameter int IDX_W      = 5,
    parameter int ALIGN_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_is_store,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [IDX_W-1:0]    req_reg_idx,
    input  logic [2*BEAT_W-1:0] req_wdata,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BEAT_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [BEAT_W-1:0]   mem_rdata,
    output logic                done,
    output logic                done_wr,
    output logic [IDX_W-1:0]    done_idx,
    output logic [2*BEAT_W-1:0] done_data
);
    localparam int BEAT_BYTES = BEAT_W / 8;
    localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((1 << ALIGN_BITS) - 1);

    qwbs_state_e      state;
    logic             accept, beat_active, beat_hi, fire_lo, fire_hi, in_done, idle;
    logic             idx_zero_in;
    logic [ADDR_W-1:0] aligned_in;
    logic [ADDR_W-1:0] addr_q;
    logic             store_q;
    logic             idx_zero_q;
    logic [IDX_W-1:0] idx_q;
    logic             commit;
    logic [BEAT_W-1:0] beat_wdata;

    assign idx_zero_in = (req_reg_idx == '0);

    qwbs_addr_gen #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .ALIGN_BITS(ALIGN_BITS)
    ) addr_i (
        .base   (req_base),
        .offset (req_offset),
        .aligned(aligned_in)
    );

    qwbs_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_store(req_is_store),
        .req_idx_zero(idx_zero_in),
        .mem_ready   (mem_ready),
        .state       (state),
        .accept      (accept),
        .beat_active (beat_active),
        .beat_hi     (beat_hi),
        .fire_lo     (fire_lo),
        .fire_hi     (fire_hi),
        .in_done     (in_done),
        .idle        (idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            store_q    <= 1'b0;
            idx_zero_q <= 1'b1;
            idx_q      <= '0;
        end else if (accept) begin
            addr_q     <= aligned_in;
            store_q    <= req_is_store;
            idx_zero_q <= idx_zero_in;
            idx_q      <= req_reg_idx;
        end
    end

    assign commit = in_done && !store_q && !idx_zero_q;

    qwbs_datapath #(
        .BEAT_W(BEAT_W)
    ) data_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .zero_src  (idx_zero_in),
        .wdata_in  (req_wdata),
        .beat_hi   (beat_hi),
        .fire_lo   (fire_lo),
        .fire_hi   (fire_hi),
        .capture_rd(!store_q),
        .rdata     (mem_rdata),
        .commit    (commit),
        .beat_wdata(beat_wdata),
        .result    (done_data)
    );

    assign req_ready = idle;
    assign mem_valid = beat_active;
    assign mem_write = beat_active && store_q;
    assign mem_addr  = beat_hi ? (addr_q + BEAT_STEP) : addr_q;
    assign mem_wdata = beat_active ? beat_wdata : '0;
    assign done      = in_done;
    assign done_wr   = commit;
    assign done_idx  = idx_q;

    // R1: every beat address is aligned apart from the half-select bit
    p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr & (LOW_MASK & ~BEAT_STEP)) == '0);

    // R3: an accepted low beat is followed by the high beat eight bytes on
    p_high_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && (mem_addr & BEAT_STEP) == '0)
        |=> mem_valid && mem_addr == $past(mem_addr) + BEAT_STEP);

    // R4: a stalled beat holds its request
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr)
            && $stable(mem_wdata) && $stable(mem_write));

    // R5: a load to index zero completes without touching memory
    p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_is_store && req_reg_idx == '0)
        |=> done && !mem_valid);

    // R7: the register write strobe only appears within the pulse
    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_wr |-> done);

    // R8: completion is a single-cycle pulse
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the idle handshake and memory activity are exclusive
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid && !done);

endmodule

// File: tb/qw_beat_splitter_tb_top.sv
`timescale 1ns/1ps
module qw_beat_splitter_tb_top;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 16;
    localparam int BEAT_W = 64;
    localparam int IDX_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_is_store = 1'b0;
    logic [ADDR_W-1:0]   req_base = '0;
    logic [OFF_W-1:0]    req_offset = '0;
    logic [IDX_W-1:0]    req_reg_idx = '0;
    logic [2*BEAT_W-1:0] req_wdata = '0;
    logic                mem_valid, mem_write;
    logic [ADDR_W-1:0]   mem_addr;
    logic [BEAT_W-1:0]   mem_wdata;
    logic                mem_ready = 1'b0;
    logic [BEAT_W-1:0]   mem_rdata = '0;
    logic                done, done_wr;
    logic [IDX_W-1:0]    done_idx;
    logic [2*BEAT_W-1:0] done_data;

    qw_beat_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_base(req_base),
        .req_offset(req_offset), .req_reg_idx(req_reg_idx),
        .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .done_wr(done_wr), .done_idx(done_idx),
        .done_data(done_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [BEAT_W-1:0] mem [0:127];
    int               cfg_wait = 0;
    int               wait_cnt = 0;
    int               tx_cnt = 0;
    logic [ADDR_W-1:0] tx_addr [0:3];
    logic              tx_wr   [0:3];
    logic [BEAT_W-1:0] tx_data [0:3];
    bit                stalled = 1'b0;
    logic [ADDR_W-1:0] st_addr;
    logic [BEAT_W-1:0] st_data;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model driven on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wait_cnt  = cfg_wait;
            stalled   = 1'b0;
        end else if (mem_valid) begin
            if (stalled) begin
                chk(mem_addr == st_addr && mem_wdata == st_data, "R4 hold",
                    {mem_addr, mem_wdata}, {st_addr, st_data});
            end
            if (wait_cnt == 0) begin
                mem_ready = 1'b1;
                mem_rdata = mem[mem_addr[9:3]];
                if (tx_cnt < 4) begin
                    tx_addr[tx_cnt] = mem_addr;
                    tx_wr[tx_cnt]   = mem_write;
                    tx_data[tx_cnt] = mem_wdata;
                end
                tx_cnt++;
                if (mem_write) mem[mem_addr[9:3]] = mem_wdata;
                wait_cnt = cfg_wait;
                stalled  = 1'b0;
            end else begin
                mem_ready = 1'b0;
                wait_cnt--;
                stalled = 1'b1;
                st_addr = mem_addr;
                st_data = mem_wdata;
            end
        end else begin
            mem_ready = 1'b0;
            wait_cnt  = cfg_wait;
            stalled   = 1'b0;
        end
    end

    task automatic do_op(input bit is_st, input logic [ADDR_W-1:0] base,
                         input int off, input logic [IDX_W-1:0] idx,
                         input logic [127:0] wd, input bit poke);
        logic [ADDR_W-1:0] al;
        logic [BEAT_W-1:0] exp_lo, exp_hi;
        logic [127:0]      exp_st;
        bit                skip;
        int                cyc;
        al     = (base + ADDR_W'(off)) & ~ADDR_W'(15);
        exp_lo = mem[al[9:3]];
        exp_hi = mem[(al[9:3] + 7'd1)];
        skip   = !is_st && idx == 0;
        exp_st = (idx == 0) ? '0 : wd;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", 128'(req_ready), 128'd1);
        tx_cnt       = 0;
        req_valid    = 1'b1;
        req_is_store = is_st;
        req_base     = base;
        req_offset   = OFF_W'(off);
        req_reg_idx  = idx;
        req_wdata    = wd;
        @(posedge clk);
        cyc = 0;
        while (cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                req_valid = poke;
                if (poke) begin
                    req_base     = base ^ 32'h0000_0240;
                    req_is_store = ~is_st;
                    req_reg_idx  = ~idx;
                end
            end else begin
                req_valid = 1'b0;
            end
            if (done) break;
        end
        if (skip) begin
            chk(cyc == 1, "R5 latency", 128'(cyc), 128'd1);
            chk(tx_cnt == 0, "R5 no beats", 128'(tx_cnt), 128'd0);
            chk(done_wr == 1'b0 && done_data == '0, "R7 no write idx0",
                {127'd0, done_wr}, 128'd0);
        end else begin
            chk(cyc == 3 + 2 * cfg_wait, "R8 latency", 128'(cyc),
                128'(3 + 2 * cfg_wait));
            chk(tx_cnt == 2, "R9 beat count", 128'(tx_cnt), 128'd2);
            chk(tx_addr[0] == al, "R1 first address", 128'(tx_addr[0]), 128'(al));
            chk(tx_addr[1] == al + 8, "R3 second address", 128'(tx_addr[1]),
                128'(al + 8));
            chk(tx_wr[0] == is_st && tx_wr[1] == is_st, "R9 write flag",
                {126'd0, tx_wr[1], tx_wr[0]}, {126'd0, is_st, is_st});
            if (is_st) begin
                chk(tx_data[0] == exp_st[63:0], (idx == 0) ? "R6 low zero" : "R2 low data",
                    128'(tx_data[0]), 128'(exp_st[63:0]));
                chk(tx_data[1] == exp_st[127:64], (idx == 0) ? "R6 high zero" : "R3 high data",
                    128'(tx_data[1]), 128'(exp_st[127:64]));
                chk(done_wr == 1'b0 && done_data == '0, "R7 store no write",
                    done_data, 128'd0);
            end else begin
                chk(done_wr == 1'b1, "R7 load write", 128'(done_wr), 128'd1);
                chk(done_idx == idx, "R7 index", 128'(done_idx), 128'(idx));
                chk(done_data[63:0] == exp_lo, "R2 load low", 128'(done_data[63:0]),
                    128'(exp_lo));
                chk(done_data[127:64] == exp_hi, "R3 load high",
                    128'(done_data[127:64]), 128'(exp_hi));
            end
        end
        @(negedge clk);
        chk(done == 1'b0 && done_wr == 1'b0, "R8 single pulse", 128'(done), 128'd0);
        chk(mem_valid == 1'b0, "R9 no restart", 128'(mem_valid), 128'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++)
            mem[i] = 64'h0123_4567_0000_0000 + 64'(i) * 64'h0000_0001_0001_0101;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && mem_valid == 1'b0, "R10 reset idle",
            {126'd0, req_ready, mem_valid}, 128'd2);
        chk(done == 1'b0 && done_wr == 1'b0 && done_data == '0, "R10 reset outputs",
            done_data, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R10 after reset",
            {125'd0, req_ready, mem_valid, done}, 128'd4);
        for (int w = 0; w < 3; w++) begin
            cfg_wait = w;
            for (int b = 0; b < 3; b++) begin
                for (int o = -17; o <= 17; o++) begin
                    logic [ADDR_W-1:0] base;
                    logic [IDX_W-1:0]  idx;
                    logic [127:0]      wd;
                    base = (b == 0) ? 32'h100 : (b == 1) ? 32'h10B : 32'h1F7;
                    idx  = IDX_W'(1 + ((o + 17 + b) % 31));
                    wd   = {32'hDEAD_0000 + 32'(o + 64), 32'h0000_BEEF ^ 32'(w),
                            32'hCAFE_0000 + 32'(b), 32'h1234_0000 + 32'(o + 100)};
                    do_op(1'b1, base, o, idx, wd, 1'b0);
                    do_op(1'b0, base, o, idx, '0, 1'b0);
                end
            end
            // R6: store from index zero writes zeros; R5: load to zero is skipped
            do_op(1'b1, 32'h2A4, 5, '0, {4{32'hFFFF_FFFF}}, 1'b0);
            do_op(1'b0, 32'h2A4, 5, 5'd7, '0, 1'b0);
            do_op(1'b0, 32'h2A4, 5, '0, '0, 1'b0);
            // R9: a request raised mid-operation is ignored
            do_op(1'b0, 32'h180, -3, 5'd9, '0, 1'b1);
            do_op(1'b1, 32'h180, 12, 5'd3, {4{32'h5A5A_A5A5}}, 1'b1);
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule